// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table out of memory. A translation request carries the virtual address. The table root address is sampled from a separate input at the moment the request is accepted. The walker then makes two dependent reads over a single memory read port. The first read uses the top index field of the address and returns an entry that points at a second-level table. The second read uses the middle index field and returns an entry that names the physical page. The 12-bit page offset passes through unchanged.

Each table entry is 32 bits wide. Bit 0 is its present flag, and bits 31..12 hold a frame number. A cleared present flag at either level ends the walk at once with a page-fault response, and that response says which level stopped the walk. Only one memory read is in flight at any time. The walker takes no new request until the consumer has taken the current response.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `xl_ready` is 1, and `rs_valid` and `mem_req` are 0. A reset in the middle of a walk returns it to this state.
- R2: The first read address is the root sampled at request acceptance plus 4 × VA[31:22]. A later change on `tbl_root` has no effect on a walk already started.
- R3: The second read address is (first-level entry bits 31..12) << 12 plus 4 × VA[21:12].
- R4: When both entries have bit 0 set, the response has `rs_fault` = 0, `rs_fault_lvl` = 0 and `rs_pa` = {second-level entry bits 31..12, VA[11:0]}. Entry bits 11..1 are ignored.
- R5: A first-level entry with bit 0 clear gives `rs_fault` = 1, `rs_fault_lvl` = 0 and `rs_pa` = 0, and no second read is made.
- R6: A second-level entry with bit 0 clear gives `rs_fault` = 1, `rs_fault_lvl` = 1 and `rs_pa` = 0.
- R7: `mem_req` stays high with a stable `mem_addr` until `mem_gnt` is seen. No new read is requested while a granted read's data is still due, so at most one read is outstanding.
- R8: `rs_valid` and the response fields hold steady until `rs_ready` is high at a clock edge. `xl_ready` is 0 from acceptance until that edge, and the walker is idle again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_valid | input | 1 | Translation request present |
| xl_ready | output | 1 | Walker can accept a request |
| xl_va | input | 32 | Virtual address to translate |
| tbl_root | input | 32 | Byte address of the first-level table, sampled on accept |
| rs_valid | output | 1 | Response present |
| rs_ready | input | 1 | Consumer takes the response |
| rs_pa | output | 32 | Physical address, 0 on a fault |
| rs_fault | output | 1 | Page fault |
| rs_fault_lvl | output | 1 | Level that faulted: 0 first, 1 second |
| mem_req | output | 1 | Memory read request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
A corrupted walk state shows up at the memory port first. It shows as a read address that is off by the root or by the index, or as a second read after a first-level fault, and it is visible at the very next grant. A lost frame or offset register shows up as a wrong physical address on the response, one cycle after the second entry returns. A wrong state order shows as a response that arrives too early, too late or never, or as `xl_ready` rising while a response is still unread. The grant delays and consumer stalls are varied so that each of these windows is opened.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int VA_W   = 2 * IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_valid,
  output logic              xl_ready,
  input  logic [VA_W-1:0]   xl_va,
  input  logic [ADDR_W-1:0] tbl_root,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [ADDR_W-1:0] rs_pa,
  output logic              rs_fault,
  output logic              rs_fault_lvl,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata
);

  localparam int FRM_W = ADDR_W - OFF_W;
  localparam int PAD_W = ADDR_W - IDX_W - 2;

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WT1, S_RD2, S_WT2, S_RSP} st_t;

  st_t               st;
  logic [VA_W-1:0]   va_q;
  logic [ADDR_W-1:0] root_q;
  logic [FRM_W-1:0]  frm_q;
  logic [ADDR_W-1:0] pa_q;
  logic              flt_q, lvl_q;

  logic [IDX_W-1:0]  idx_hi, idx_lo;
  logic [ADDR_W-1:0] addr_l1, addr_l2;
  logic              ent_ok;
  logic [FRM_W-1:0]  ent_frm;
  logic              unused_ent_bits;

  assign idx_hi  = va_q[VA_W-1 -: IDX_W];
  assign idx_lo  = va_q[OFF_W +: IDX_W];
  assign addr_l1 = root_q + {{PAD_W{1'b0}}, idx_hi, 2'b00};
  assign addr_l2 = {frm_q, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, idx_lo, 2'b00};
  assign ent_ok  = mem_rdata[0];
  assign ent_frm = mem_rdata[ADDR_W-1:OFF_W];
  assign unused_ent_bits = ^mem_rdata[OFF_W-1:1];

  assign xl_ready     = (st == S_IDLE);
  assign rs_valid     = (st == S_RSP);
  assign rs_pa        = pa_q;
  assign rs_fault     = flt_q;
  assign rs_fault_lvl = lvl_q;
  assign mem_req      = (st == S_RD1) || (st == S_RD2);
  assign mem_addr     = (st == S_RD2) ? addr_l2 : addr_l1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      root_q <= '0;
      frm_q  <= '0;
      pa_q   <= '0;
      flt_q  <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (xl_valid) begin
          va_q   <= xl_va;
          root_q <= tbl_root;
          st     <= S_RD1;
        end
        S_RD1: if (mem_gnt) st <= S_WT1;
        S_WT1: if (mem_rvalid) begin
          if (ent_ok) begin
            frm_q <= ent_frm;
            st    <= S_RD2;
          end else begin
            pa_q  <= '0;
            flt_q <= 1'b1;
            lvl_q <= 1'b0;
            st    <= S_RSP;
          end
        end
        S_RD2: if (mem_gnt) st <= S_WT2;
        S_WT2: if (mem_rvalid) begin
          pa_q  <= ent_ok ? {ent_frm, va_q[OFF_W-1:0]} : '0;
          flt_q <= ~ent_ok;
          lvl_q <= ~ent_ok;
          st    <= S_RSP;
        end
        S_RSP: if (rs_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xl_valid,
  input logic              xl_ready,
  input logic [OFF_W-1:0]  xl_off,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic [ADDR_W-1:0] rs_pa,
  input logic              rs_fault,
  input logic              rs_fault_lvl,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid
);

  logic [OFF_W-1:0] off_q;
  logic [1:0]       outst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
      outst <= '0;
    end else begin
      if (xl_valid && xl_ready) off_q <= xl_off;
      case ({mem_req && mem_gnt, mem_rvalid && (outst != 2'd0)})
        2'b10:   outst <= outst + 2'd1;
        2'b01:   outst <= outst - 2'd1;
        default: outst <= outst;
      endcase
    end
  end

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ready |-> !rs_valid && !mem_req);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> outst == 2'd0);

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_pa) && $stable(rs_fault) && $stable(rs_fault_lvl));

  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> !xl_ready);

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_fault |-> rs_pa[OFF_W-1:0] == off_q && !rs_fault_lvl);

  a_r5_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && rs_fault |-> rs_pa == '0);

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xl_valid(xl_valid), .xl_ready(xl_ready),
  .xl_off(xl_va[OFF_W-1:0]), .rs_valid(rs_valid), .rs_ready(rs_ready),
  .rs_pa(rs_pa), .rs_fault(rs_fault), .rs_fault_lvl(rs_fault_lvl),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xl_valid = 1'b0, xl_ready;
  logic [31:0] xl_va = '0, tbl_root = '0;
  logic rs_valid, rs_ready = 1'b0;
  logic [31:0] rs_pa;
  logic rs_fault, rs_fault_lvl;
  logic mem_req, mem_gnt;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .xl_valid(xl_valid), .xl_ready(xl_ready), .xl_va(xl_va),
    .tbl_root(tbl_root), .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pa(rs_pa),
    .rs_fault(rs_fault), .rs_fault_lvl(rs_fault_lvl), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int ntot = 0, nbad = 0;
  bit done = 0;
  logic [31:0] mem [0:4095];
  logic [31:0] glog [0:3];
  int ngnt = 0, gdly = 0, gcnt = 0, pcnt = 0;
  bit pend = 0;
  logic [31:0] paddr;

  assign mem_gnt = mem_req && (gcnt >= gdly);

  always @(posedge clk) begin
    if (!rst_n) begin
      pend = 0;
      gcnt <= 0;
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      gcnt <= (mem_req && !mem_gnt) ? gcnt + 1 : 0;
      if (pend) begin
        if (pcnt == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata <= mem[paddr[13:2]];
          pend = 0;
        end else pcnt--;
      end
      if (mem_req && mem_gnt) begin
        pend = 1; pcnt = 1; paddr = mem_addr;
        if (ngnt < 4) glog[ngnt] = mem_addr;
        ngnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] va, input logic [31:0] base_a, input logic [31:0] base_b,
                     input int gd, input int hold, input logic [31:0] epa, input bit ef, input bit el);
    logic [31:0] e1, e2;
    int k;
    @(negedge clk);
    gdly = gd; ngnt = 0;
    xl_va = va; tbl_root = base_a; xl_valid = 1'b1;
    chk(xl_ready, "R8 ready before accept", {31'd0, xl_ready}, 32'd1);
    @(negedge clk);
    xl_valid = 1'b0; tbl_root = base_b;
    chk(!xl_ready, "R8 busy after accept", {31'd0, xl_ready}, 32'd0);
    k = 0;
    while (!rs_valid && k < 200) begin @(negedge clk); k++; end
    chk(rs_valid, "R8 response arrives", {31'd0, rs_valid}, 32'd1);
    chk(rs_pa == epa, ef ? (el ? "R6 pa" : "R5 pa") : "R4 pa", rs_pa, epa);
    chk(rs_fault == ef, ef ? (el ? "R6 fault" : "R5 fault") : "R4 fault", {31'd0, rs_fault}, {31'd0, ef});
    chk(rs_fault_lvl == el, ef ? (el ? "R6 level" : "R5 level") : "R4 level", {31'd0, rs_fault_lvl}, {31'd0, el});
    e1 = base_a + {20'd0, va[31:22], 2'b00};
    chk(glog[0] == e1, "R2 first read address", glog[0], e1);
    if (!ef || el) begin
      e2 = {mem[e1[13:2]][31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
      chk(ngnt == 2, "R3 two reads", ngnt, 2);
      chk(glog[1] == e2, "R3 second read address", glog[1], e2);
    end else begin
      chk(ngnt == 1, "R5 single read", ngnt, 1);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rs_valid && rs_pa == epa && !xl_ready, "R8 hold while stalled", rs_pa, epa);
    end
    rs_ready = 1'b1;
    @(negedge clk);
    rs_ready = 1'b0;
    chk(!rs_valid && xl_ready, "R8 idle after take", {30'd0, rs_valid, xl_ready}, 32'd1);
  endtask

  // {va, pa, fault, level}
  localparam logic [65:0] VEC [0:8] = '{
    {32'h0000_0123, 32'h0ABC_D123, 1'b0, 1'b0},
    {32'h0000_5FFF, 32'h1234_5FFF, 1'b0, 1'b0},
    {32'h003F_F000, 32'hFFFF_F000, 1'b0, 1'b0},
    {32'h007F_FABC, 32'h0077_7ABC, 1'b0, 1'b0},
    {32'h0040_1001, 32'h0099_9001, 1'b0, 1'b0},
    {32'h0080_0010, 32'h0000_0000, 1'b1, 1'b0},
    {32'h0000_7444, 32'h0000_0000, 1'b1, 1'b1},
    {32'h0000_8888, 32'h0000_0000, 1'b1, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b0}
  };

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem['h400] = 32'h0000_2001;  mem['h401] = 32'h0000_3001;  mem['h402] = 32'h0000_4000;
    mem['h800] = 32'h0ABC_D001;  mem['h805] = 32'h1234_5003;  mem['hBFF] = 32'hFFFF_F001;
    mem['h808] = 32'h5555_5000;  mem['hFFF] = 32'h0077_7001;  mem['hC01] = 32'h0099_9001;
    mem['h200] = 32'h0000_3001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(xl_ready && !rs_valid && !mem_req, "R1 reset state",
        {29'd0, xl_ready, rs_valid, mem_req}, 32'd4);

    for (int i = 0; i < 9; i++)
      run(VEC[i][65:34], 32'h1000, 32'h1000, i % 3, (i % 2) * 3,
          VEC[i][33:2], VEC[i][1], VEC[i][0]);

    // R2: root is sampled on accept; a later change must not redirect the walk
    run(32'h0000_1055, 32'h0800, 32'h1000, 3, 1, 32'h0099_9055, 1'b0, 1'b0);

    // R1: reset in the middle of a walk
    @(negedge clk);
    gdly = 0; xl_va = 32'h0000_0123; tbl_root = 32'h1000; xl_valid = 1'b1;
    @(negedge clk);
    xl_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(xl_ready && !rs_valid && !mem_req, "R1 reset mid-walk",
        {29'd0, xl_ready, rs_valid, mem_req}, 32'd4);
    repeat (4) @(negedge clk);
    chk(xl_ready && !rs_valid, "R1 stays idle after reset",
        {30'd0, xl_ready, rs_valid}, 32'd2);

    run(32'h0000_0123, 32'h1000, 32'h0, 0, 0, 32'h0ABC_D123, 1'b0, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", ntot, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      ntot++; nbad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", ntot, nbad);
      $finish;
    end
  end
endmodule